// File: doc/BRIEF.md
# Streaming Row-Sum Reduction Scheduler

This block turns a stream of row-tagged values into one total per row while using a single adder pipeline that is PIPE_LAT cycles deep. Values arrive at most one per clock. All values of one row arrive together, one row after the next, and a row may hold any number of values. The block never stalls its input while a sum is in flight. Each cycle a fixed priority order picks the two adder operands. The sources are the value leaving the adder, the head of an input FIFO, the second FIFO entry, a parked partial sum, or zero. Partial sums of different rows therefore share the pipeline.

A partial sum that leaves the adder and cannot be merged at once is parked in a small partial-sum buffer. The row is finished when a later row has started, none of its partials remain in the pipeline or the FIFO, and its parked entry is the only piece left. That entry then leaves as the row total with its row tag. Integer addition stands in for the floating-point adder; the scheduling is unchanged if a real adder is used.

Top module: `rowSumScheduler`

## Requirements
- R1: A value is taken when inValid and inReady are both high in the same cycle. inReady is low exactly while the input FIFO holds FIFO_DEPTH values. inRow and inValue are ignored while inValid is low.
- R2: Every emitted outSum equals the sum, modulo 2^VAL_W, of all values accepted with that row index. A launched addition reaches the adder output PIPE_LAT cycles after launch.
- R3: After reset outValid is low. Each row is reported exactly once, as a single-cycle outValid pulse with its index on outRow.
- R4: The operand choice follows a fixed priority. First: adder output plus a parked partial of the same row. Then: adder output plus FIFO head of the same row. Then: the two front FIFO entries, if they hold the same row. Then: the FIFO head plus zero, if the FIFO holds at least two values. Otherwise an empty slot with its valid bit low enters the pipeline.
- R5: While the FIFO holds fewer than two values and the adder output matches nothing, nothing is launched. A single value on its own therefore never produces an output.
- R6: The partial-sum buffer holds at most one entry per row. With BUF_DEPTH of at least 2*PIPE_LAT+4 it never overflows, so no partial sum is lost.
- R7: A row total is emitted only after a value of a later row has been accepted and no partial of that row is left in the pipeline or the FIFO. Row indices must change only at a row boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value offered |
| inValue | input | VAL_W | Value to add |
| inRow | input | ROW_W | Row index of the value |
| inReady | output | 1 | FIFO can take a value |
| outValid | output | 1 | One-cycle pulse: row total present |
| outRow | output | ROW_W | Row index of the total |
| outSum | output | VAL_W | Row total |

## Verification
A wrong operand choice or a lost partial shows up at the ports as a wrong outSum, a missing row, or a row reported twice. The first two appear once the row closes, within a few multiples of PIPE_LAT after the next row's first value. A completion test that fires too early splits one row into two reports, and the second report is caught as a duplicate. If completion never fires, or a lone value is launched wrongly, the result is a missing total or a total that appears before any later row exists. These faults are looked for at two pipeline depths, across row lengths from 1 to 16, with idle gaps and garbage driven on the data pins between values.

// File: rtl/rowSumPkg.sv
package rowSumPkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_BUF_OUT,
    OP_HEAD_OUT,
    OP_HEAD_PAIR,
    OP_HEAD_ZERO
  } opSelT;

  typedef struct packed {
    opSelT opSel;
    logic  insert;
    logic  emit;
  } ctrlStrobeT;

endpackage

// File: rtl/rowSumDatapath.sv
module rowSumDatapath
  import rowSumPkg::*;
#(
  parameter int VAL_W      = 16,
  parameter int ROW_W      = 8,
  parameter int PIPE_LAT   = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int BUF_DEPTH  = 12,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [VAL_W-1:0]                  inValue,
  input  logic [ROW_W-1:0]                  inRow,
  output logic                              inReady,
  input  ctrlStrobeT                        strobe,
  input  logic [BUF_DEPTH-1:0]              matchHot,
  input  logic [BUF_DEPTH-1:0]              insHot,
  input  logic [BUF_DEPTH-1:0]              emitHot,
  output logic [CNT_W-1:0]                  fifoCount,
  output logic [ROW_W-1:0]                  headRow,
  output logic [ROW_W-1:0]                  nextRow,
  output logic [ROW_W-1:0]                  lastRow,
  output logic                              lastRowValid,
  output logic [PIPE_LAT-1:0]               pipeValid,
  output logic [PIPE_LAT-1:0][ROW_W-1:0]    pipeRow,
  output logic [BUF_DEPTH-1:0]              bufValid,
  output logic [BUF_DEPTH-1:0][ROW_W-1:0]   bufRow,
  output logic                              outValid,
  output logic [ROW_W-1:0]                  outRow,
  output logic [VAL_W-1:0]                  outSum
);

  logic [FIFO_DEPTH-1:0][VAL_W-1:0] memVal;
  logic [FIFO_DEPTH-1:0][ROW_W-1:0] memRow;
  logic [PTR_W-1:0] rdPtr, wrPtr, nxPtr;
  logic [PIPE_LAT-1:0][VAL_W-1:0] pipeVal;
  logic [BUF_DEPTH-1:0][VAL_W-1:0] bufVal;

  logic             push;
  logic [1:0]       popN;
  logic [VAL_W-1:0] headVal, nextVal, adderOutVal, bufSelVal, emitVal;
  logic [ROW_W-1:0] adderOutRow, emitRow;
  logic [VAL_W-1:0] opA, opB;
  logic             launchValid;
  logic [ROW_W-1:0] launchRow;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nxPtr       = incPtr(rdPtr);
  assign headRow     = memRow[rdPtr];
  assign nextRow     = memRow[nxPtr];
  assign headVal     = memVal[rdPtr];
  assign nextVal     = memVal[nxPtr];
  assign inReady     = (fifoCount != CNT_W'(FIFO_DEPTH));
  assign push        = inValid && inReady;
  assign adderOutVal = pipeVal[PIPE_LAT-1];
  assign adderOutRow = pipeRow[PIPE_LAT-1];

  // one-hot selections of buffer slots
  always_comb begin
    bufSelVal = '0;
    emitVal   = '0;
    emitRow   = '0;
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (matchHot[i]) bufSelVal = bufSelVal | bufVal[i];
      if (emitHot[i]) begin
        emitVal = emitVal | bufVal[i];
        emitRow = emitRow | bufRow[i];
      end
    end
  end

  // operand routing per scheduling decision
  always_comb begin
    popN        = 2'd0;
    opA         = '0;
    opB         = '0;
    launchValid = 1'b1;
    launchRow   = headRow;
    unique case (strobe.opSel)
      OP_BUF_OUT: begin
        opA = adderOutVal; opB = bufSelVal; launchRow = adderOutRow;
      end
      OP_HEAD_OUT: begin
        opA = adderOutVal; opB = headVal; launchRow = adderOutRow; popN = 2'd1;
      end
      OP_HEAD_PAIR: begin
        opA = headVal; opB = nextVal; popN = 2'd2;
      end
      OP_HEAD_ZERO: begin
        opA = headVal; popN = 2'd1;
      end
      default: launchValid = 1'b0;
    endcase
  end

  // input FIFO
  always_ff @(posedge clk) begin
    if (push) begin
      memVal[wrPtr] <= inValue;
      memRow[wrPtr] <= inRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr        <= '0;
      wrPtr        <= '0;
      fifoCount    <= '0;
      lastRowValid <= 1'b0;
      lastRow      <= '0;
    end else begin
      if (push) begin
        wrPtr        <= incPtr(wrPtr);
        lastRow      <= inRow;
        lastRowValid <= 1'b1;
      end
      if (popN == 2'd1) rdPtr <= nxPtr;
      else if (popN == 2'd2) rdPtr <= incPtr(nxPtr);
      fifoCount <= fifoCount + CNT_W'(push) - CNT_W'(popN);
    end
  end

  // adder pipeline carrying valid and row tag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeValid <= '0;
    end else begin
      pipeValid[0] <= launchValid;
      for (int s = 1; s < PIPE_LAT; s++) pipeValid[s] <= pipeValid[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pipeVal[0] <= opA + opB;
    pipeRow[0] <= launchRow;
    for (int s = 1; s < PIPE_LAT; s++) begin
      pipeVal[s] <= pipeVal[s-1];
      pipeRow[s] <= pipeRow[s-1];
    end
  end

  // partial-sum buffer
  always_ff @(posedge clk) begin
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (!rstN) begin
        bufValid[i] <= 1'b0;
      end else if (matchHot[i] || emitHot[i]) begin
        bufValid[i] <= 1'b0;
      end else if (strobe.insert && insHot[i]) begin
        bufValid[i] <= 1'b1;
        bufRow[i]   <= adderOutRow;
        bufVal[i]   <= adderOutVal;
      end
    end
  end

  // registered completed-row output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.emit;
    end
    outRow <= emitRow;
    outSum <= emitVal;
  end

  // R1: occupancy follows accepted pushes and scheduled pops
  a_r1_fifo_count: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fifoCount == $past(fifoCount) + CNT_W'($past(push)) - CNT_W'($past(popN)));

  a_r1_fifo_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));

  // R5: no pop beyond what the FIFO holds
  a_r5_pop_holds: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(popN) <= fifoCount);

  // R2: every launch enters stage zero, every stage advances one per cycle
  a_r2_launch: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.opSel != OP_IDLE) |=> pipeValid[0]);

  for (genvar s = 1; s < PIPE_LAT; s++) begin : g_stepChk
    a_r2_stage_step: assert property (@(posedge clk) disable iff (!rstN)
      pipeValid[s-1] |=> pipeValid[s] && pipeRow[s] == $past(pipeRow[s-1]));
  end

endmodule

// File: rtl/rowSumControl.sv
module rowSumControl
  import rowSumPkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int PIPE_LAT   = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int BUF_DEPTH  = 12,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CNT_W-1:0]                fifoCount,
  input  logic [ROW_W-1:0]                headRow,
  input  logic [ROW_W-1:0]                nextRow,
  input  logic [ROW_W-1:0]                lastRow,
  input  logic                            lastRowValid,
  input  logic [PIPE_LAT-1:0]             pipeValid,
  input  logic [PIPE_LAT-1:0][ROW_W-1:0]  pipeRow,
  input  logic [BUF_DEPTH-1:0]            bufValid,
  input  logic [BUF_DEPTH-1:0][ROW_W-1:0] bufRow,
  output ctrlStrobeT                      strobe,
  output logic [BUF_DEPTH-1:0]            matchHot,
  output logic [BUF_DEPTH-1:0]            insHot,
  output logic [BUF_DEPTH-1:0]            emitHot
);

  logic             outV;
  logic [ROW_W-1:0] outR;
  logic             hasOne, hasTwo;
  logic             hitBuf, hitHead, hitPair;
  logic [BUF_DEPTH-1:0] freeVec, doneVec, inFlight;

  assign outV    = pipeValid[PIPE_LAT-1];
  assign outR    = pipeRow[PIPE_LAT-1];
  assign hasOne  = (fifoCount != '0);
  assign hasTwo  = (fifoCount >= CNT_W'(2));

  for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_slot
    assign matchHot[i] = outV && bufValid[i] && (bufRow[i] == outR);

    always_comb begin
      inFlight[i] = 1'b0;
      for (int s = 0; s < PIPE_LAT; s++)
        if (pipeValid[s] && pipeRow[s] == bufRow[i]) inFlight[i] = 1'b1;
    end

    assign doneVec[i] = bufValid[i] && lastRowValid && (bufRow[i] != lastRow)
                        && !inFlight[i] && !(hasOne && headRow == bufRow[i]);
  end

  assign hitBuf  = |matchHot;
  assign hitHead = outV && hasOne && (headRow == outR);
  assign hitPair = hasTwo && (headRow == nextRow);

  // fixed priority operand choice
  always_comb begin
    if (hitBuf)       strobe.opSel = OP_BUF_OUT;
    else if (hitHead) strobe.opSel = OP_HEAD_OUT;
    else if (hitPair) strobe.opSel = OP_HEAD_PAIR;
    else if (hasTwo)  strobe.opSel = OP_HEAD_ZERO;
    else              strobe.opSel = OP_IDLE;
  end

  assign strobe.insert = outV && !hitBuf && !hitHead;
  assign freeVec       = ~bufValid;
  assign insHot        = strobe.insert ? (freeVec & (~freeVec + 1'b1)) : '0;
  assign emitHot       = doneVec & (~doneVec + 1'b1);
  assign strobe.emit   = |doneVec;

  // R6: a partial parked in the buffer always finds a free slot
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.insert |-> (|freeVec));

  // R6: at most one parked partial per row
  a_r6_single_partial: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchHot));

  // R7: a closing slot is never the one being merged
  a_r7_emit_not_merged: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> ((emitHot & matchHot) == '0));

endmodule

// File: rtl/rowSumScheduler.sv
module rowSumScheduler
  import rowSumPkg::*;
#(
  parameter int VAL_W      = 16,
  parameter int ROW_W      = 8,
  parameter int PIPE_LAT   = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int BUF_DEPTH  = 2 * PIPE_LAT + 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VAL_W-1:0] inValue,
  input  logic [ROW_W-1:0] inRow,
  output logic             inReady,
  output logic             outValid,
  output logic [ROW_W-1:0] outRow,
  output logic [VAL_W-1:0] outSum
);

  ctrlStrobeT                      strobe;
  logic [BUF_DEPTH-1:0]            matchHot, insHot, emitHot;
  logic [CNT_W-1:0]                fifoCount;
  logic [ROW_W-1:0]                headRow, nextRow, lastRow;
  logic                            lastRowValid;
  logic [PIPE_LAT-1:0]             pipeValid;
  logic [PIPE_LAT-1:0][ROW_W-1:0]  pipeRow;
  logic [BUF_DEPTH-1:0]            bufValid;
  logic [BUF_DEPTH-1:0][ROW_W-1:0] bufRow;

  rowSumDatapath #(
    .VAL_W(VAL_W), .ROW_W(ROW_W), .PIPE_LAT(PIPE_LAT),
    .FIFO_DEPTH(FIFO_DEPTH), .BUF_DEPTH(BUF_DEPTH)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inValue(inValue), .inRow(inRow), .inReady(inReady),
    .strobe(strobe), .matchHot(matchHot), .insHot(insHot), .emitHot(emitHot),
    .fifoCount(fifoCount), .headRow(headRow), .nextRow(nextRow),
    .lastRow(lastRow), .lastRowValid(lastRowValid),
    .pipeValid(pipeValid), .pipeRow(pipeRow),
    .bufValid(bufValid), .bufRow(bufRow),
    .outValid(outValid), .outRow(outRow), .outSum(outSum)
  );

  rowSumControl #(
    .ROW_W(ROW_W), .PIPE_LAT(PIPE_LAT),
    .FIFO_DEPTH(FIFO_DEPTH), .BUF_DEPTH(BUF_DEPTH)
  ) control_i (
    .clk(clk), .rstN(rstN),
    .fifoCount(fifoCount), .headRow(headRow), .nextRow(nextRow),
    .lastRow(lastRow), .lastRowValid(lastRowValid),
    .pipeValid(pipeValid), .pipeRow(pipeRow),
    .bufValid(bufValid), .bufRow(bufRow),
    .strobe(strobe), .matchHot(matchHot), .insHot(insHot), .emitHot(emitHot)
  );

endmodule

// File: tb/rowSumScheduler_tb_top.sv
module rowSumScheduler_tb_top;

  localparam int NROWS = 20;
  localparam int ROW_LEN [NROWS] = '{1,1,1,3,2,7,1,12,4,1,1,5,9,2,2,16,1,3,6,1};
  localparam int GAP     [NROWS] = '{0,0,2,0,0,5,0,0,1,0,0,0,3,0,0,0,0,7,0,0};
  localparam int LAST_ROW = NROWS;        // rows 0..NROWS are real
  localparam int SENTINEL = NROWS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inValue = '0;
  logic [7:0]  inRow = '0;
  logic readyA, readyB;
  logic outValidA, outValidB;
  logic [7:0]  outRowA, outRowB;
  logic [15:0] outSumA, outSumB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] expSum [256];
  bit          pushed [256];
  int          got    [2][256];

  always #2 clk = ~clk;

  rowSumScheduler #(.PIPE_LAT(4)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue), .inRow(inRow),
    .inReady(readyA), .outValid(outValidA), .outRow(outRowA), .outSum(outSumA));

  rowSumScheduler #(.PIPE_LAT(9), .FIFO_DEPTH(5)) dutDeep_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue), .inRow(inRow),
    .inReady(readyB), .outValid(outValidB), .outRow(outRowB), .outSum(outSumB));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic seeEmit(input int k, input logic [7:0] r, input logic [15:0] s);
    check(pushed[r], "R7 total for a row never pushed", int'(r), -1);
    check(got[k][r] == 0, "R3 row reported twice", got[k][r], 0);
    check(s == expSum[r], "R2 R4 row total", int'(s), int'(expSum[r]));
    got[k][r]++;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (outValidA) seeEmit(0, outRowA, outSumA);
      if (outValidB) seeEmit(1, outRowB, outSumB);
    end
  end

  task automatic pushVal(input int r, input logic [15:0] v);
    while (!(readyA && readyB)) begin
      inValid = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b1;
    inRow   = 8'(r);
    inValue = v;
    expSum[r] = expSum[r] + v;
    pushed[r] = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    inRow   = 8'($urandom);   // R1: garbage while invalid
    inValue = 16'($urandom);
  endtask

  function automatic logic [15:0] valOf(input int r, input int k);
    return 16'((r * 37 + k * 11 + 3 + r * k * 509) & 16'hFFFF);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      expSum[i] = '0;
      pushed[i] = 1'b0;
      got[0][i] = 0;
      got[1][i] = 0;
    end
    repeat (4) @(negedge clk);
    // R3, R1: reset state
    check(outValidA == 1'b0 && outValidB == 1'b0, "R3 outValid in reset", int'(outValidA), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(readyA && readyB, "R1 inReady after reset", int'(readyA), 1);
    check(!outValidA && !outValidB, "R3 outValid after reset", int'(outValidA), 0);

    // R5, R7: a lone value produces nothing
    pushVal(0, 16'd5);
    repeat (40) @(negedge clk);
    check(got[0][0] == 0 && got[1][0] == 0, "R5 lone value emitted", got[0][0], 0);

    // table walk: rows 1..NROWS
    for (int n = 0; n < NROWS; n++) begin
      for (int k = 0; k < ROW_LEN[n]; k++) pushVal(n + 1, valOf(n + 1, k));
      repeat (GAP[n]) @(negedge clk);
    end

    // last real row is still open: no later row yet
    repeat (60) @(negedge clk);
    check(got[0][LAST_ROW] == 0, "R7 open row emitted early", got[0][LAST_ROW], 0);
    check(got[0][LAST_ROW - 1] == 1, "R7 closed row emitted", got[0][LAST_ROW - 1], 1);

    pushVal(SENTINEL, 16'd1);
    repeat (200) @(negedge clk);

    for (int r = 0; r <= LAST_ROW; r++) begin
      check(got[0][r] == 1, "R6 row total count (shallow)", got[0][r], 1);
      check(got[1][r] == 1, "R6 row total count (deep)", got[1][r], 1);
    end
    check(got[0][SENTINEL] == 0 && got[1][SENTINEL] == 0,
          "R7 sentinel row emitted", got[0][SENTINEL], 0);
    check(readyA && readyB, "R1 inReady when drained", int'(readyA && readyB), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule